// File: doc/BRIEF.md
# Ordered Three-Step Dial Lock Controller

This block is a synchronous finite state machine for a dial combination lock. It opens only after three dial operations arrive in one fixed order. An operation is a single-cycle strobe that carries a turn direction and a dial position. The default combination is right to 13, then left to 22, then right to 3. The block tracks how far the user has progressed through that combination. When the last step lands, it raises an unlock output. That output stays high until a relock pulse arrives.

Four progress states are kept:

- Idle: closed, with nothing useful entered yet.
- First step done.
- First two steps done.
- Open.

The current state code is driven out for debug. The combination is fixed at elaboration through parameters and cannot be changed at run time.

Top module: `seq_lock`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is idle (code 2'b00) and `unlock_o` is low.
- R2: In idle, a valid operation with direction right (`op_dir_i` = 0) and position 13 moves the state to 2'b01.
- R3: In state 2'b01, a valid operation with direction left (`op_dir_i` = 1) and position 22 moves the state to 2'b10.
- R4: In state 2'b10, a valid operation with direction right and position 3 moves the state to 2'b11, the open state.
- R5: `unlock_o` is high exactly when `state_o` equals 2'b11. It changes in the same cycle as the state.
- R6: A cycle with `op_valid_i` low and `relock_i` low leaves the state unchanged.
- R7: In states 2'b00, 2'b01 and 2'b10, a valid operation that is not the expected next step returns the state to 2'b00. This includes a repeat of an earlier correct step.
- R8: In state 2'b11, valid operations are ignored and the state stays 2'b11 until relock.
- R9: `relock_i` high at a clock edge returns the state to 2'b00 from any state. It takes priority over a valid operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| relock_i | input | 1 | Return to idle and close the lock |
| op_valid_i | input | 1 | Marks a dial operation in this cycle |
| op_dir_i | input | 1 | Turn direction: 0 right, 1 left |
| op_pos_i | input | 5 | Dial position of the operation |
| unlock_o | output | 1 | High while the lock is open |
| state_o | output | 2 | Current progress state code |

## Verification
The bench first drives the lock into each of the four states. From each state it applies every direction and position pair, and compares the resulting state and unlock against an arithmetic model.

- A design that checked only the position and not the direction would open on left-13 or right-22.
- A design that stayed put on a wrong step, or treated a repeated right-13 as progress, would leave the state at 2'b01 instead of idle.

Further cases cover behaviour that is easy to get wrong:

- Idle gaps between steps, which a design that forgot to gate on the valid strobe would count as a wrong step and reset on.
- Operations received while open, which a design without the open-state hold would use to fall back to idle.
- Relock arriving together with a correct step, which a design with the wrong priority would use to advance.

// File: rtl/lock_pkg.sv
package lock_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_STEP1 = 2'b01,
    ST_STEP2 = 2'b10,
    ST_OPEN  = 2'b11
  } lock_state_t;

  localparam int unsigned NUM_STEPS = 3;
endpackage

// File: rtl/lock_step_match.sv
module lock_step_match
  import lock_pkg::*;
#(
  parameter int unsigned POS_W = 5,
  parameter logic [NUM_STEPS-1:0] SEQ_DIR = 3'b010,
  parameter logic [NUM_STEPS*POS_W-1:0] SEQ_POS = {5'd3, 5'd22, 5'd13}
) (
  input  lock_state_t      state_i,
  input  logic             dir_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             hit_o
);
  logic [NUM_STEPS-1:0] step_hit;

  // One comparator per combination step; the current state selects which one counts.
  for (genvar k = 0; k < NUM_STEPS; k++) begin : g_step
    assign step_hit[k] = (dir_i == SEQ_DIR[k]) && (pos_i == SEQ_POS[k*POS_W +: POS_W]);
  end

  always_comb begin
    unique case (state_i)
      ST_IDLE:  hit_o = step_hit[0];
      ST_STEP1: hit_o = step_hit[1];
      ST_STEP2: hit_o = step_hit[2];
      default:  hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import lock_pkg::*;
(
  input  lock_state_t state_i,
  input  logic        relock_i,
  input  logic        valid_i,
  input  logic        hit_i,
  output lock_state_t next_o
);
  always_comb begin
    next_o = state_i;
    if (relock_i) begin
      next_o = ST_IDLE;
    end else if (valid_i && state_i != ST_OPEN) begin
      if (hit_i) begin
        unique case (state_i)
          ST_IDLE:  next_o = ST_STEP1;
          ST_STEP1: next_o = ST_STEP2;
          default:  next_o = ST_OPEN;
        endcase
      end else begin
        next_o = ST_IDLE;
      end
    end
  end
endmodule

// File: rtl/seq_lock.sv
module seq_lock
  import lock_pkg::*;
#(
  parameter int unsigned POS_W = 5,
  parameter logic [NUM_STEPS-1:0] SEQ_DIR = 3'b010,
  parameter logic [NUM_STEPS*POS_W-1:0] SEQ_POS = {5'd3, 5'd22, 5'd13}
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             relock_i,
  input  logic             op_valid_i,
  input  logic             op_dir_i,
  input  logic [POS_W-1:0] op_pos_i,
  output logic             unlock_o,
  output logic [1:0]       state_o
);
  lock_state_t state_q, state_d;
  logic        hit;
  logic        unlock_q;

  lock_step_match #(
    .POS_W  (POS_W),
    .SEQ_DIR(SEQ_DIR),
    .SEQ_POS(SEQ_POS)
  ) u_match (
    .state_i(state_q),
    .dir_i  (op_dir_i),
    .pos_i  (op_pos_i),
    .hit_o  (hit)
  );

  lock_next_state u_next (
    .state_i (state_q),
    .relock_i(relock_i),
    .valid_i (op_valid_i),
    .hit_i   (hit),
    .next_o  (state_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      unlock_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      unlock_q <= (state_d == ST_OPEN);
    end
  end

  assign state_o  = state_q;
  assign unlock_o = unlock_q;

  p_reset_idle_r1: assert property (@(posedge clk) rst |=> (state_o == 2'b00 && !unlock_o));

  p_step1_r2: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !relock_i && state_o == 2'b00 && !op_dir_i && op_pos_i == POS_W'(13)
     && SEQ_POS == {5'd3, 5'd22, 5'd13}) |=> state_o == 2'b01);

  p_step2_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !relock_i && state_o == 2'b01 && hit) |=> state_o == 2'b10);

  p_step3_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !relock_i && state_o == 2'b10 && hit) |=> state_o == 2'b11);

  p_unlock_moore_r5: assert property (@(posedge clk) disable iff (rst)
    unlock_o == (state_o == 2'b11));

  p_hold_idle_cycle_r6: assert property (@(posedge clk) disable iff (rst)
    (!op_valid_i && !relock_i) |=> $stable(state_o));

  p_mismatch_back_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid_i && !relock_i && state_o != 2'b11 && !hit) |=> state_o == 2'b00);

  p_open_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'b11 && !relock_i) |=> state_o == 2'b11);

  p_relock_wins_r9: assert property (@(posedge clk) disable iff (rst)
    relock_i |=> (state_o == 2'b00 && !unlock_o));
endmodule

// File: tb/seq_lock_tb.sv
module seq_lock_tb;
  logic       clk = 1'b0;
  logic       rst;
  logic       relock_i;
  logic       op_valid_i;
  logic       op_dir_i;
  logic [4:0] op_pos_i;
  logic       unlock_o;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  seq_lock u_dut (
    .clk       (clk),
    .rst       (rst),
    .relock_i  (relock_i),
    .op_valid_i(op_valid_i),
    .op_dir_i  (op_dir_i),
    .op_pos_i  (op_pos_i),
    .unlock_o  (unlock_o),
    .state_o   (state_o)
  );

  // Reference model written from the requirements
  function automatic logic [1:0] model_next(input logic [1:0] s, input logic rl,
                                            input logic v, input logic d, input logic [4:0] p);
    logic ok;
    if (rl) return 2'b00;        // R9
    if (!v) return s;            // R6
    if (s == 2'b11) return s;    // R8
    ok = (s == 2'b00 && d == 1'b0 && p == 5'd13) ||
         (s == 2'b01 && d == 1'b1 && p == 5'd22) ||
         (s == 2'b10 && d == 1'b0 && p == 5'd3);
    return ok ? s + 2'd1 : 2'b00; // R2 R3 R4 R7
  endfunction

  task automatic check(input string req, input logic [1:0] exp_s);
    checks++;
    if (state_o !== exp_s) begin
      errors++;
      $display("FAIL %s state=%b expected=%b", req, state_o, exp_s);
    end
    checks++;
    if (unlock_o !== (exp_s == 2'b11)) begin
      errors++;
      $display("FAIL %s unlock=%b expected=%b (R5)", req, unlock_o, exp_s == 2'b11);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic cycle(input logic rl, input logic v, input logic d, input logic [4:0] p);
    @(negedge clk);
    relock_i = rl; op_valid_i = v; op_dir_i = d; op_pos_i = p;
    @(posedge clk);
    @(negedge clk);
    relock_i = 1'b0; op_valid_i = 1'b0;
  endtask

  task automatic go_state(input logic [1:0] s);
    cycle(1'b1, 1'b0, 1'b0, 5'd0);
    if (s >= 2'd1) cycle(1'b0, 1'b1, 1'b0, 5'd13);
    if (s >= 2'd2) cycle(1'b0, 1'b1, 1'b1, 5'd22);
    if (s == 2'd3) cycle(1'b0, 1'b1, 1'b0, 5'd3);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; relock_i = 1'b0; op_valid_i = 1'b0; op_dir_i = 1'b0; op_pos_i = '0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    check("R1 reset", 2'b00);
    rst = 1'b0;

    // Sweep all states and all operations
    for (int s = 0; s < 4; s++) begin
      for (int d = 0; d < 2; d++) begin
        for (int p = 0; p < 32; p++) begin
          go_state(2'(s));
          check("R2/R3/R4 reach", 2'(s));
          cycle(1'b0, 1'b1, 1'(d), 5'(p));
          if (s == 3) check("R8 sweep", model_next(2'(s), 1'b0, 1'b1, 1'(d), 5'(p)));
          else check("R7 sweep", model_next(2'(s), 1'b0, 1'b1, 1'(d), 5'(p)));
        end
      end
    end

    // Idle gaps between steps
    go_state(2'd0);
    cycle(1'b0, 1'b1, 1'b0, 5'd13);
    for (int g = 0; g < 3; g++) begin
      cycle(1'b0, 1'b0, 1'b1, 5'd7);
      check("R6 gap after step1", 2'b01);
    end
    cycle(1'b0, 1'b1, 1'b1, 5'd22);
    cycle(1'b0, 1'b0, 1'b0, 5'd0);
    check("R6 gap after step2", 2'b10);
    cycle(1'b0, 1'b1, 1'b0, 5'd3);
    check("R4 open after gaps", 2'b11);

    // Repeated correct prefix
    go_state(2'd0);
    cycle(1'b0, 1'b1, 1'b0, 5'd13);
    cycle(1'b0, 1'b1, 1'b0, 5'd13);
    check("R7 repeated step1", 2'b00);
    cycle(1'b0, 1'b1, 1'b0, 5'd13);
    cycle(1'b0, 1'b1, 1'b1, 5'd22);
    cycle(1'b0, 1'b1, 1'b1, 5'd22);
    check("R7 repeated step2", 2'b00);

    // Open state holds over idle cycles and ops, then relock
    go_state(2'd3);
    cycle(1'b0, 1'b0, 1'b0, 5'd0);
    check("R6 open idle", 2'b11);
    cycle(1'b0, 1'b1, 1'b0, 5'd13);
    check("R8 open ignores", 2'b11);
    cycle(1'b1, 1'b0, 1'b0, 5'd0);
    check("R9 relock from open", 2'b00);

    // Relock priority over a correct step, from every state
    for (int s = 0; s < 3; s++) begin
      go_state(2'(s));
      if (s == 0) cycle(1'b1, 1'b1, 1'b0, 5'd13);
      if (s == 1) cycle(1'b1, 1'b1, 1'b1, 5'd22);
      if (s == 2) cycle(1'b1, 1'b1, 1'b0, 5'd3);
      check("R9 relock priority", 2'b00);
    end

    // Reset mid-sequence
    go_state(2'd2);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); @(negedge clk); rst = 1'b0;
    check("R1 reset mid-sequence", 2'b00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule